// File: doc/BRIEF.md
# Paged 32-bit Register Access Engine

This block gives a host single-command access to 32-bit registers that sit behind a management bus whose transactions move only 16 bits at a time. The host presents an operation (read, write or read-modify-write), a register address, write data and a bit mask, then pulses `start`. The engine breaks the address into a page number, a management device address and an even register number. It writes the page number to a fixed page-select location and waits a settling interval derived from the clock frequency. It then moves the two 16-bit halves of the register, low half first.

Every access is one uninterrupted sequence on the management request/acknowledge interface. A read-modify-write selects the page once, reads both halves, merges the new bits under the mask and writes both halves back. The host gets a one-cycle `done` pulse and a 32-bit result. The serial frame generator that carries each 16-bit transaction sits outside the block, behind the `mg_*` handshake.

Top module: `paged_reg_engine`

## Requirements
- R1: The register number is `(addr >> 1) & 0x1E`, so it is always even and `addr[0]` is ignored. The low half uses that register number and the high half uses the number plus one.
- R2: Data transactions target device address `0x10 | ((addr >> 6) & 7)`, which always lies in the range 16 to 23.
- R3: Every access begins with a 16-bit write of the page number `(addr >> 9) & 0x1FF` to device address 0x18, register 0.
- R4: After the page write is acknowledged, no request is raised for exactly `ceil(CLK_HZ * SETTLE_US / 1e6)` cycles (250 at 50 MHz and 5 us). The first data request follows in the next cycle.
- R5: A read (`op` = 0) fetches the low half and then the high half, and returns `{high, low}` on `rdata`. Code 3 behaves as a read.
- R6: A write (`op` = 1) sends `wdata[15:0]` first and `wdata[31:16]` second, and returns `wdata` on `rdata`.
- R7: A read-modify-write (`op` = 2) reads both halves, forms `(old & ~mask) | wdata`, and writes that value back low half first with no second page write. It returns the written value.
- R8: A request holds its fields until it is acknowledged, and each acknowledge ends exactly one transaction. No request is raised while the engine is idle, and nothing else is interleaved inside a sequence.
- R9: `busy` is high from the cycle after `start` is accepted until completion. A `start` that arrives while busy is ignored and causes no transactions.
- R10: `done` is a one-cycle pulse and `busy` is low in that cycle. Synchronous active-high reset leaves the engine idle, with `busy`, `done` and `mg_req` low and `rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an access (accepted only when idle) |
| op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| addr | input | ADDR_W | 32-bit register byte address |
| wdata | input | 32 | Write data, or bits to set for read-modify-write |
| mask | input | 32 | Bits to clear for read-modify-write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read value or final written value |
| mg_req | output | 1 | Management transaction request |
| mg_write | output | 1 | 1 write, 0 read |
| mg_phy | output | 5 | Management device address |
| mg_reg | output | 5 | Management register number |
| mg_wdata | output | 16 | Write half-word |
| mg_ack | input | 1 | Transaction complete; read data valid this cycle |
| mg_rdata | input | 16 | Read half-word |

## Verification
The assertions take for granted that the management side raises `mg_ack` only while `mg_req` is high, for a single cycle, and with `mg_rdata` valid in that cycle. The bench's responder keeps to this rule and varies the acknowledge latency from zero to three cycles. The assertions also expect the host to keep `op`, `addr`, `wdata` and `mask` valid in the cycle `start` is sampled. The bench drives them with `start` and changes them only in a later cycle, including for the stray `start` it issues mid-sequence.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int MDEV_W  = 5;
    localparam int MREG_W  = 5;
    localparam int SUB_W   = 3;
    localparam int PAGE_W  = 9;

    localparam logic [MDEV_W-1:0] PAGE_DEV      = 5'h18;
    localparam logic [MREG_W-1:0] PAGE_REG      = 5'h00;
    localparam logic [MDEV_W-1:0] DATA_DEV_BASE = 5'h10;
    localparam logic [MREG_W-1:0] REG_EVEN_MASK = 5'h1E;

    // Address bits consumed after the initial shift by one
    localparam int SUB_LSB  = MREG_W;
    localparam int PAGE_LSB = MREG_W + SUB_W;
    localparam int USED_MSB = 1 + PAGE_LSB + PAGE_W - 1;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RMW   = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PAGE,
        S_SETTLE,
        S_RD_LO,
        S_RD_HI,
        S_WR_LO,
        S_WR_HI
    } seq_state_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [MDEV_W-1:0] dev;
        logic [MREG_W-1:0] reg_lo;
    } mgmt_loc_t;

    typedef struct packed {
        op_e               op;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] mask;
    } host_cmd_t;

    function automatic int settle_cycles(input int clk_hz, input int settle_us);
        longint prod;
        longint cyc;
        prod = longint'(clk_hz) * longint'(settle_us);
        cyc  = (prod + 64'd999_999) / 64'd1_000_000;
        if (cyc < 1) cyc = 1;
        return int'(cyc);
    endfunction

    function automatic logic [WORD_W-1:0] merge_bits(input logic [WORD_W-1:0] old_v,
                                                     input logic [WORD_W-1:0] mask_v,
                                                     input logic [WORD_W-1:0] set_v);
        return (old_v & ~mask_v) | set_v;
    endfunction

endpackage

// File: rtl/regacc_addr_map.sv
module regacc_addr_map
    import regacc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output mgmt_loc_t         loc
);
    logic [ADDR_W-1:0] shifted;
    logic              unused_bits;

    assign shifted     = addr >> 1;
    assign loc.reg_lo  = shifted[MREG_W-1:0] & REG_EVEN_MASK;
    assign loc.dev     = DATA_DEV_BASE | {{(MDEV_W-SUB_W){1'b0}}, shifted[SUB_LSB +: SUB_W]};
    assign loc.page    = shifted[PAGE_LSB +: PAGE_W];
    assign unused_bits = ^{addr[0], addr[ADDR_W-1:USED_MSB+1]};

endmodule

// File: rtl/regacc_settle_timer.sv
module regacc_settle_timer #(
    parameter int CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = (CYC < 2) ? 1 : $clog2(CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/regacc_seq.sv
module regacc_seq
    import regacc_pkg::*;
#(
    parameter int SETTLE_CYC = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  host_cmd_t         cmd_in,
    input  mgmt_loc_t         loc_in,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              mg_req,
    output logic              mg_write,
    output logic [MDEV_W-1:0] mg_phy,
    output logic [MREG_W-1:0] mg_reg,
    output logic [HALF_W-1:0] mg_wdata,
    input  logic              mg_ack,
    input  logic [HALF_W-1:0] mg_rdata
);
    seq_state_e        state_q;
    host_cmd_t         cmd_q;
    mgmt_loc_t         loc_q;
    logic [HALF_W-1:0] lo_q;
    logic [WORD_W-1:0] wr_val_q;
    logic [WORD_W-1:0] res_q;
    logic              done_q;
    logic              settle_load;
    logic              settle_done;
    logic [MREG_W-1:0] reg_hi;

    assign settle_load = (state_q == S_PAGE) && mg_ack;
    assign reg_hi      = {loc_q.reg_lo[MREG_W-1:1], 1'b1};

    regacc_settle_timer #(.CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (settle_load),
        .expired (settle_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            cmd_q    <= '0;
            loc_q    <= '0;
            lo_q     <= '0;
            wr_val_q <= '0;
            res_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        cmd_q    <= cmd_in;
                        loc_q    <= loc_in;
                        wr_val_q <= cmd_in.wdata;
                        state_q  <= S_PAGE;
                    end
                end
                S_PAGE: begin
                    if (mg_ack) state_q <= S_SETTLE;
                end
                S_SETTLE: begin
                    if (settle_done) begin
                        state_q <= (cmd_q.op == OP_WRITE) ? S_WR_LO : S_RD_LO;
                    end
                end
                S_RD_LO: begin
                    if (mg_ack) begin
                        lo_q    <= mg_rdata;
                        state_q <= S_RD_HI;
                    end
                end
                S_RD_HI: begin
                    if (mg_ack) begin
                        if (cmd_q.op == OP_RMW) begin
                            wr_val_q <= merge_bits({mg_rdata, lo_q}, cmd_q.mask, cmd_q.wdata);
                            state_q  <= S_WR_LO;
                        end else begin
                            res_q   <= {mg_rdata, lo_q};
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end
                    end
                end
                S_WR_LO: begin
                    if (mg_ack) state_q <= S_WR_HI;
                end
                S_WR_HI: begin
                    if (mg_ack) begin
                        res_q   <= wr_val_q;
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mg_req   = 1'b0;
        mg_write = 1'b0;
        mg_phy   = loc_q.dev;
        mg_reg   = loc_q.reg_lo;
        mg_wdata = '0;
        unique case (state_q)
            S_PAGE: begin
                mg_req   = 1'b1;
                mg_write = 1'b1;
                mg_phy   = PAGE_DEV;
                mg_reg   = PAGE_REG;
                mg_wdata = {{(HALF_W-PAGE_W){1'b0}}, loc_q.page};
            end
            S_RD_LO: mg_req = 1'b1;
            S_RD_HI: begin
                mg_req = 1'b1;
                mg_reg = reg_hi;
            end
            S_WR_LO: begin
                mg_req   = 1'b1;
                mg_write = 1'b1;
                mg_wdata = wr_val_q[HALF_W-1:0];
            end
            S_WR_HI: begin
                mg_req   = 1'b1;
                mg_write = 1'b1;
                mg_reg   = reg_hi;
                mg_wdata = wr_val_q[WORD_W-1:HALF_W];
            end
            default: ;
        endcase
    end

    assign busy  = (state_q != S_IDLE);
    assign done  = done_q;
    assign rdata = res_q;

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(cmd_q) && $stable(loc_q))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_RMW_NO_REPAGE: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WR_LO && cmd_q.op == OP_RMW) |-> (mg_phy != PAGE_DEV)); // R7

endmodule

// File: rtl/paged_reg_engine.sv
module paged_reg_engine
    import regacc_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SETTLE_US = 5,
    parameter int ADDR_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] mask,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              mg_req,
    output logic              mg_write,
    output logic [MDEV_W-1:0] mg_phy,
    output logic [MREG_W-1:0] mg_reg,
    output logic [HALF_W-1:0] mg_wdata,
    input  logic              mg_ack,
    input  logic [HALF_W-1:0] mg_rdata
);
    localparam int SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_US);
    localparam int GAP_W      = $clog2(SETTLE_CYC + 2);

    mgmt_loc_t loc;
    host_cmd_t cmd;

    assign cmd.op    = op_e'(op);
    assign cmd.wdata = wdata;
    assign cmd.mask  = mask;

    regacc_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .addr (addr),
        .loc  (loc)
    );

    regacc_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd_in   (cmd),
        .loc_in   (loc),
        .busy     (busy),
        .done     (done),
        .rdata    (rdata),
        .mg_req   (mg_req),
        .mg_write (mg_write),
        .mg_phy   (mg_phy),
        .mg_reg   (mg_reg),
        .mg_wdata (mg_wdata),
        .mg_ack   (mg_ack),
        .mg_rdata (mg_rdata)
    );

    // Cycles since the last acknowledged page write, saturating at the settle length
    logic [GAP_W-1:0] since_page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_page_q <= '0;
        end else if (mg_req && mg_ack && mg_phy == PAGE_DEV) begin
            since_page_q <= '0;
        end else if (since_page_q != GAP_W'(SETTLE_CYC)) begin
            since_page_q <= since_page_q + 1'b1;
        end
    end

    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (rst)
        (mg_req && mg_phy != PAGE_DEV) |-> (since_page_q == GAP_W'(SETTLE_CYC))); // R4

    AST_DATA_DEV_RANGE: assert property (@(posedge clk) disable iff (rst)
        (mg_req && mg_phy != PAGE_DEV) |-> (mg_phy[4:3] == 2'b10)); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mg_req && !mg_ack) |=> (mg_req && $stable(mg_phy) && $stable(mg_reg)
                                 && $stable(mg_write) && $stable(mg_wdata))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mg_req); // R8

    AST_PAGE_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (mg_req && mg_phy == PAGE_DEV) |-> (mg_write && mg_reg == PAGE_REG)); // R3

endmodule

// File: tb/paged_reg_engine_test.sv
module paged_reg_engine_test;
    import regacc_pkg::*;

    localparam int SETTLE = 250;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] mask = '0;
    logic        busy, done;
    logic [31:0] rdata;
    logic        mg_req, mg_write;
    logic [4:0]  mg_phy, mg_reg;
    logic [15:0] mg_wdata;
    logic        mg_ack = 1'b0;
    logic [15:0] mg_rdata = '0;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    paged_reg_engine uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr),
        .wdata(wdata), .mask(mask), .busy(busy), .done(done), .rdata(rdata),
        .mg_req(mg_req), .mg_write(mg_write), .mg_phy(mg_phy), .mg_reg(mg_reg),
        .mg_wdata(mg_wdata), .mg_ack(mg_ack), .mg_rdata(mg_rdata)
    );

    typedef struct {
        bit    wr;
        int    dev;
        int    rg;
        int    data;
        string tag;
    } txn_t;

    txn_t exp_q[$];
    logic [15:0] mem [int];
    int cur_page = 0;
    int lat_cfg  = 0;
    int wait_cnt = 0;
    bit gap_on   = 0;
    int gap      = 0;

    function automatic int mkey(int pg, int dv, int rg);
        return pg * 1024 + dv * 32 + rg;
    endfunction

    function automatic logic [15:0] mem_rd(int k);
        if (mem.exists(k)) return mem[k];
        return 16'(k * 40503) ^ 16'h5A5A;
    endfunction

    task automatic check(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Monitor / responder / scoreboard
    always @(negedge clk) begin
        if (gap_on) begin
            if (!mg_req) gap++;
            else begin
                check(gap == SETTLE, "R4 settle gap", gap, SETTLE);
                gap_on = 0;
            end
        end
        if (mg_ack) begin
            mg_ack = 1'b0;
        end else if (mg_req && !rst) begin
            if (wait_cnt >= lat_cfg) begin
                wait_cnt = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected transaction", mg_phy, 0);
                end else begin
                    txn_t e;
                    e = exp_q.pop_front();
                    check(mg_write == e.wr && int'(mg_phy) == e.dev && int'(mg_reg) == e.rg
                          && (!e.wr || int'(mg_wdata) == e.data), e.tag,
                          {mg_write, mg_phy, mg_reg, mg_wdata},
                          {e.wr, 5'(e.dev), 5'(e.rg), 16'(e.data)});
                end
                if (mg_write && mg_phy == 5'h18 && mg_reg == 5'h0) begin
                    cur_page = int'(mg_wdata);
                    gap_on = 1;
                    gap = 0;
                end else if (mg_write) begin
                    mem[mkey(cur_page, mg_phy, mg_reg)] = mg_wdata;
                end else begin
                    mg_rdata = mem_rd(mkey(cur_page, mg_phy, mg_reg));
                end
                mg_ack = 1'b1;
            end else begin
                wait_cnt++;
            end
        end
    end

    // Driver: pushes the expected transactions, then runs one access
    task automatic run_op(int opc, logic [31:0] a, logic [31:0] wd, logic [31:0] mk,
                          int lat, bit inject, string rtag);
        int r1, dv, pg;
        logic [31:0] old_v, expv;
        r1 = int'((a >> 1) & 32'h1E);
        dv = 16 | int'((a >> 6) & 32'h7);
        pg = int'((a >> 9) & 32'h1FF);
        old_v = {mem_rd(mkey(pg, dv, r1 + 1)), mem_rd(mkey(pg, dv, r1))};
        exp_q.push_back('{1, 24, 0, pg, "R3 page write"});
        if (opc == 1) begin
            expv = wd;
            exp_q.push_back('{1, dv, r1, int'(wd[15:0]), "R6 write low first (R1 R2)"});
            exp_q.push_back('{1, dv, r1 + 1, int'(wd[31:16]), "R6 write high second (R1 R2)"});
        end else begin
            exp_q.push_back('{0, dv, r1, 0, "R5 read low first (R1 R2)"});
            exp_q.push_back('{0, dv, r1 + 1, 0, "R5 read high second (R1 R2)"});
            expv = old_v;
            if (opc == 2) begin
                expv = (old_v & ~mk) | wd;
                exp_q.push_back('{1, dv, r1, int'(expv[15:0]), "R7 merged write low"});
                exp_q.push_back('{1, dv, r1 + 1, int'(expv[31:16]), "R7 merged write high"});
            end
        end
        lat_cfg = lat;
        @(negedge clk);
        op = 2'(opc); addr = a; wdata = wd; mask = mk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        if (inject) begin
            repeat (5) @(negedge clk);
            op = 2'd1; addr = 32'h0001_FF00; wdata = 32'hFFFF_FFFF; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(rdata == expv, rtag, rdata, expv);
        check(busy == 1'b0, "R10 busy low with done", busy, 0);
        check(exp_q.size() == 0, "R8 all transactions seen", exp_q.size(), 0);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", done, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(mg_req == 1'b0 && busy == 1'b0, "R9 idle after access (no stray start)",
                  {busy, mg_req}, 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && mg_req == 0 && rdata == 0, "R10 reset state",
              {busy, done, mg_req}, 0);
        rst = 1'b0;
        run_op(0, 32'h0000_0000, 32'h0, 32'h0, 0, 0, "R5 read data");
        run_op(1, 32'h0003_FFFE, 32'hDEAD_BEEF, 32'h0, 1, 0, "R6 write returns wdata");
        run_op(0, 32'h0003_FFFE, 32'h0, 32'h0, 2, 0, "R5 read back");
        run_op(2, 32'h0003_FFFE, 32'h0000_1200, 32'h0000_FF00, 3, 0, "R7 rmw result");
        run_op(0, 32'h0003_FFFE, 32'h0, 32'h0, 0, 0, "R7 rmw stored DEAD12EF");
        check(rdata == 32'hDEAD_12EF, "R7 literal merge", rdata, 32'hDEAD_12EF);
        run_op(2, 32'h0000_1234, 32'hCAFE_F00D, 32'hFFFF_FFFF, 1, 1, "R9 rmw with stray start");
        run_op(1, 32'h0001_0041, 32'h1357_9BDF, 32'h0, 2, 0, "R1 write odd address");
        run_op(0, 32'h0001_0040, 32'h0, 32'h0, 0, 0, "R1 even alias reads odd write");
        run_op(3, 32'h0001_0040, 32'h0, 32'h0, 1, 0, "R5 code 3 acts as read");
        run_op(2, 32'h0000_2A80, 32'h0, 32'h0, 2, 0, "R7 zero mask keeps value");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule